// File: doc/BRIEF.md
# Serial Dual-Wiper Code Register with Daisy-Chain Output

This block is the device-side serial front end of a two-channel digital potentiometer. While the frame-enable input is high, each rising clock edge moves one bit from the serial data input into a 17-bit shift register. The register carries two 8-bit wiper codes and one stack-select bit. When the frame enable falls, the register contents are copied into holding registers. These registers drive the two wiper codes and the stack-select output.

The far end of the shift register is always visible on a cascade output, whatever the frame enable is doing. Several devices can therefore be chained by feeding each cascade output into the next data input. A controller can also read the register back by feeding the cascade output of the last device into the first data input and clocking the chain all the way around. The stack-select bit joins the two wipers into a single 9-bit position with 512 steps. That position is reported on a combined output.

The shift register keeps its own layout. Bit 16 is the stack select, bits 15:8 hold the wiper-1 code and bits 7:0 hold the wiper-0 code. A controller sends the stack-select bit first and the wiper-0 least significant bit last.

Top module: `potreg_top`

## Requirements
- R1: After reset, both wiper codes, the stack select, the combined position and the cascade output are all zero.
- R2: On each rising clock edge where the frame enable is high, the shift register moves one place toward bit 16 and takes the data input into bit 0. After 17 such edges the register holds the last 17 bits sent, with the first of them in bit 16.
- R3: Clock edges where the frame enable is low leave the shift register unchanged, whatever the data input is doing.
- R4: The cascade output equals bit 16 of the shift register at all times, with no extra register stage. It stays valid while the frame enable is low.
- R5: At the start of a transaction, the first bit to leave the cascade output is the stack-select bit of the register contents.
- R6: On the first clock edge that samples the frame enable low after it was sampled high, the register is loaded into the holding registers: bit 16 to stack select, bits 15:8 to the wiper-1 code, bits 7:0 to the wiper-0 code.
- R7: The holding registers keep their value at every other edge, including the edges during a frame.
- R8: The combined 9-bit position is {stack select, wiper-0 code} when the stack select is 0, and {stack select, wiper-1 code} when it is 1. It spans 0 to 511.
- R9: Clocking 17 bits with the cascade output fed back into the data input leaves the register, and so the reloaded holding registers, unchanged.
- R10: A frame longer than 17 bits loads only the last 17 bits sent. The earlier bits pass out through the cascade output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising edge active |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_en | input | 1 | High while a transfer frame is in progress |
| din | input | 1 | Serial data input |
| cas_out | output | 1 | Far end of the shift register, used for daisy chaining and read-back |
| wiper0_code | output | 8 | Held wiper-0 code |
| wiper1_code | output | 8 | Held wiper-1 code |
| stack_sel | output | 1 | Held stack-select bit |
| stack_pos | output | 9 | Combined 9-bit wiper position |

## Verification
Frames are sent with the stack select both clear and set, and with mixed, all-ones and all-zeros codes. These patterns separate the field layout, the routing of the selected wiper and the 0 and 511 ends of the combined position. During each frame, the cascade output is compared bit by bit against the previous contents, which shows the shift order and that the stack-select bit leaves first. A frame with leading extra bits shows that only the last 17 bits count. An idle stretch with a toggling data input, followed by a circular read-back, shows that nothing shifts outside a frame and that a full loop restores the register.

// File: rtl/potreg_pkg.sv
package potreg_pkg;

  localparam int unsigned WIPER_W_DEF = 8;
  localparam int unsigned NUM_WIPERS  = 2;

  function automatic int unsigned frame_width(input int unsigned wiper_w);
    return NUM_WIPERS * wiper_w + 1;
  endfunction

endpackage

// File: rtl/potreg_rst_sync.sv
module potreg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/potreg_shifter.sv
module potreg_shifter #(
  parameter int unsigned FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_en,
  input  logic               din,
  output logic [FRAME_W-1:0] sreg_o,
  output logic               cas_o
);

  logic [FRAME_W-1:0] sreg_q;
  logic [FRAME_W-1:0] sreg_d;
  logic               shift_en;

  assign shift_en = frame_en;

  always_comb begin
    sreg_d = {sreg_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (shift_en) begin
      sreg_q <= sreg_d;
    end
  end

  // far end straight from the register, no extra stage
  assign cas_o  = sreg_q[FRAME_W-1];
  assign sreg_o = sreg_q;

endmodule

// File: rtl/potreg_hold.sv
module potreg_hold #(
  parameter int unsigned FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_en,
  input  logic [FRAME_W-1:0] sreg_i,
  output logic [FRAME_W-1:0] hold_o
);

  logic               en_q;
  logic               load;
  logic [FRAME_W-1:0] hold_q;
  logic [FRAME_W-1:0] hold_d;

  assign load = en_q & ~frame_en;

  always_comb begin
    hold_d = sreg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= frame_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/potreg_stack_mux.sv
module potreg_stack_mux #(
  parameter int unsigned WIPER_W = 8
) (
  input  logic               sel,
  input  logic [WIPER_W-1:0] code0,
  input  logic [WIPER_W-1:0] code1,
  output logic [WIPER_W:0]   pos
);

  logic [WIPER_W-1:0] picked;

  always_comb begin
    picked = sel ? code1 : code0;
    pos    = {sel, picked};
  end

endmodule

// File: rtl/potreg_top.sv
module potreg_top
  import potreg_pkg::*;
#(
  parameter int unsigned WIPER_W    = WIPER_W_DEF,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               frame_en,
  input  logic               din,
  output logic               cas_out,
  output logic [WIPER_W-1:0] wiper0_code,
  output logic [WIPER_W-1:0] wiper1_code,
  output logic               stack_sel,
  output logic [WIPER_W:0]   stack_pos
);

  localparam int unsigned FRAME_W = frame_width(WIPER_W);
  localparam int unsigned SEL_IDX = FRAME_W - 1;

  logic                           rst_n_sync;
  logic [FRAME_W-1:0]             sreg;
  logic [FRAME_W-1:0]             hold;
  logic [NUM_WIPERS-1:0][WIPER_W-1:0] codes;

  potreg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_sync)
  );

  potreg_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .frame_en (frame_en),
    .din      (din),
    .sreg_o   (sreg),
    .cas_o    (cas_out)
  );

  potreg_hold #(.FRAME_W(FRAME_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .frame_en (frame_en),
    .sreg_i   (sreg),
    .hold_o   (hold)
  );

  // wiper i occupies bits [i*W +: W]; the selector sits above them all
  for (genvar i = 0; i < NUM_WIPERS; i++) begin : g_field
    assign codes[i] = hold[i*WIPER_W +: WIPER_W];
  end

  assign wiper0_code = codes[0];
  assign wiper1_code = codes[1];
  assign stack_sel   = hold[SEL_IDX];

  potreg_stack_mux #(.WIPER_W(WIPER_W)) u_mux (
    .sel   (stack_sel),
    .code0 (codes[0]),
    .code1 (codes[1]),
    .pos   (stack_pos)
  );

endmodule

// File: rtl/potreg_checker.sv
module potreg_checker #(
  parameter int unsigned WIPER_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_en,
  input logic                 din,
  input logic [2*WIPER_W:0]   sreg,
  input logic                 cas_out,
  input logic [WIPER_W-1:0]   wiper0_code,
  input logic [WIPER_W-1:0]   wiper1_code,
  input logic                 stack_sel,
  input logic [WIPER_W:0]     stack_pos
);

  localparam int unsigned FW = 2 * WIPER_W + 1;

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |=> sreg == {$past(sreg[FW-2:0]), $past(din)});

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> $stable(sreg));

  p_end_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_en) && !frame_en) |=>
      {stack_sel, wiper1_code, wiper0_code} == $past(sreg));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(frame_en) && !frame_en) |=>
      $stable({stack_sel, wiper1_code, wiper0_code}));

  p_first_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_en) && !frame_en) |=> cas_out == stack_sel);

  p_pos_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_pos == {stack_sel, (stack_sel ? wiper1_code : wiper0_code)});

endmodule

bind potreg_top potreg_checker #(.WIPER_W(WIPER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .frame_en    (frame_en),
  .din         (din),
  .sreg        (sreg),
  .cas_out     (cas_out),
  .wiper0_code (wiper0_code),
  .wiper1_code (wiper1_code),
  .stack_sel   (stack_sel),
  .stack_pos   (stack_pos)
);

// File: tb/potreg_top_test.sv
`timescale 1ns/1ps
module potreg_top_test;

  localparam int W  = 8;
  localparam int FW = 2 * W + 1;

  logic         clk;
  logic         arst_n;
  logic         frame_en;
  logic         din;
  logic         cas_out;
  logic [W-1:0] wiper0_code;
  logic [W-1:0] wiper1_code;
  logic         stack_sel;
  logic [W:0]   stack_pos;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [FW-1:0] exp_q[$];

  potreg_top uut (
    .clk(clk), .arst_n(arst_n), .frame_en(frame_en), .din(din),
    .cas_out(cas_out), .wiper0_code(wiper0_code), .wiper1_code(wiper1_code),
    .stack_sel(stack_sel), .stack_pos(stack_pos)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W:0] exp_pos(input logic [FW-1:0] f);
    return f[FW-1] ? {1'b1, f[2*W-1:W]} : {1'b0, f[W-1:0]};
  endfunction

  // driver: shifts a frame in, stack bit first, optionally checking the old contents leaving
  task automatic send_frame(input logic [FW-1:0] f, input bit chk_cas, input logic [FW-1:0] prev);
    exp_q.push_back(f);
    for (int k = FW - 1; k >= 0; k--) begin
      @(negedge clk);
      if (chk_cas) begin
        if (k == FW - 1) check("R5 stack bit first out", cas_out, prev[k]);
        else             check("R4 cascade bit", cas_out, prev[k]);
        if (k == W)      check("R7 hold during frame", {stack_sel, wiper1_code, wiper0_code}, prev);
      end
      frame_en = 1'b1;
      din      = f[k];
    end
    @(negedge clk);
    frame_en = 1'b0;
    din      = 1'b0;
  endtask

  task automatic send_junk(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      frame_en = 1'b1;
      din      = j[0];
    end
  endtask

  // monitor: one expected item per frame end
  initial begin
    forever begin
      @(negedge frame_en);
      @(posedge clk);
      #1;
      if (exp_q.size() == 0) begin
        check("R6 unexpected frame end", 1, 0);
      end else begin
        logic [FW-1:0] e;
        e = exp_q.pop_front();
        check("R6 wiper0 load", wiper0_code, e[W-1:0]);
        check("R6 wiper1 load", wiper1_code, e[2*W-1:W]);
        check("R6 stack load", stack_sel, e[FW-1]);
        check("R8 combined position", stack_pos, exp_pos(e));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa, fb, fc, fd, fe, cur;
    logic          cas_hold;
    arst_n = 1'b0; frame_en = 1'b0; din = 1'b0;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 wiper0 reset", wiper0_code, 0);
    check("R1 wiper1 reset", wiper1_code, 0);
    check("R1 stack reset", stack_sel, 0);
    check("R1 position reset", stack_pos, 0);
    check("R1 cascade reset", cas_out, 0);

    fa = {1'b0, 8'hA5, 8'h3C};
    fb = {1'b1, 8'hF0, 8'h0F};
    fc = {1'b1, 8'hFF, 8'h00};
    fd = {1'b0, 8'h00, 8'h00};
    fe = {1'b1, 8'h5A, 8'hC3};

    send_frame(fa, 1'b1, '0);     // R2 shift order checked via cascade in next frame
    send_frame(fb, 1'b1, fa);     // R2 R4 R5: old contents leave stack bit first
    send_frame(fc, 1'b1, fb);     // R8 top end 511
    send_frame(fd, 1'b1, fc);     // R8 bottom end 0
    @(negedge clk);
    check("R8 position 0 after all-zero frame", stack_pos, 0);

    // R10: 5 extra leading bits, then a full frame
    send_junk(5);
    send_frame(fe, 1'b0, '0);
    repeat (2) @(negedge clk);
    check("R10 long frame keeps last bits", {stack_sel, wiper1_code, wiper0_code}, fe);

    // R3 and R4: idle clocks with toggling data leave the register alone
    cas_hold = cas_out;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      din = ~din;
      check("R3 cascade stable while idle", cas_out, cas_hold);
    end
    check("R4 cascade shows stack bit while idle", cas_out, fe[FW-1]);
    check("R7 hold stable while idle", {stack_sel, wiper1_code, wiper0_code}, fe);
    din = 1'b0;

    // R9: circular read-back restores the same contents
    @(negedge clk);
    cur = {stack_sel, wiper1_code, wiper0_code};
    exp_q.push_back(cur);
    for (int k = 0; k < FW; k++) begin
      frame_en = 1'b1;
      din      = cas_out;
      @(negedge clk);
    end
    frame_en = 1'b0;
    din      = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 read-back unchanged", {stack_sel, wiper1_code, wiper0_code}, cur);
    check("R9 cascade back at stack bit", cas_out, cur[FW-1]);

    repeat (3) @(negedge clk);
    check("R6 all frames consumed", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule